// File: doc/BRIEF.md
# I2C Controller Interrupt Aggregator

This block collects the interrupt events of an I2C controller into one level interrupt line. Ten event sources arrive as single-cycle pulses and are held in a raw status register until software clears them. Two more sources, the receive-threshold and transmit-threshold conditions, are not held: they follow their level inputs directly. A software-written enable mask selects which raw bits may raise the interrupt line. Software can read the masked view, the raw view and the mask.

Clearing is done by reads. Each held source has its own clear address, so clearing one event never discards another event that arrived after the status was read. A single global clear address also exists. When a transmit abort is signalled, a reason vector is accumulated alongside it. That reason vector is kept until the abort bit is cleared, either by its own clear address or by the global clear.

Top module: `irq_aggr_top`

## Requirements
- R1: Status bit positions are: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit threshold, 5 read request, 6 transmit abort, 7 receive done, 8 bus activity, 9 stop seen, 10 start seen, 11 general call. A pulse on `evt_i[b]` for any bit other than 2 and 4 sets raw bit b at the next clock edge. The bit stays set until it is cleared.
- R2: Raw bit 2 equals `rx_full_lvl_i` and raw bit 4 equals `tx_empty_lvl_i` at all times. `evt_i[2]`, `evt_i[4]` and reads of their clear addresses (18, 20) have no effect, and those clear reads return 0.
- R3: Register reads use these addresses: 0 gives the masked status, 1 gives the raw status, 2 gives the mask, 3 gives the abort reason, 4 is the global clear. Addresses 16+b are the per-source clears for bit b. Any other address reads 0. The masked status is the raw status ANDed with the mask.
- R4: A read of address 16+b, for a held bit b, returns that bit's value in bit 0. The read clears raw bit b only.
- R5: A read of address 4 returns 1 in bit 0 when any held bit is set, and 0 otherwise. The read clears all held bits and the abort reason.
- R6: While `evt_i[6]` pulses, `abrt_rsn_i` is ORed into the abort reason register. The reason holds until a read of address 22 or address 4 clears it.
- R7: If a bit's event arrives in the same cycle as a clear of that bit, the bit ends up set. If an abort event coincides with a reason clear, the reason becomes the new `abrt_rsn_i` value.
- R8: `irq_o` is high exactly when any masked status bit is set, with no added delay.
- R9: Reset (synchronous, active high) zeroes the mask, the held bits, the abort reason and the read data. A write with `wr_en_i` to address 2 loads the mask from `wdata_i[11:0]`.
- R10: Read data appears on `rdata_o` after the clock edge on which `rd_en_i` is sampled. It holds until the next read. The read returns state from before any clear made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 12 | Event pulses, one per status bit |
| rx_full_lvl_i | input | 1 | Receive threshold condition (status bit 2) |
| tx_empty_lvl_i | input | 1 | Transmit threshold condition (status bit 4) |
| abrt_rsn_i | input | 13 | Abort reason bits that accompany an `evt_i[6]` pulse |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
An event pulse or a clear read takes effect at the edge on which it is sampled. The interrupt line is combinational from that state and from the two level inputs. It is therefore due in the same cycle, right after the edge or right after a level input changes. Read data is due one edge after the read strobe and keeps the state from before that edge. The bench drives all inputs 1 ns after the rising edge and advances its model on the same rising edge the design uses. It compares `irq_o` and `rdata_o` at every falling edge, and it makes its directed read checks 1 ns after the edge that captured the read.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int NSRC   = 12;
    localparam int ABRT_W = 13;

    // status bit positions (decoded by software, so fixed)
    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_TX_ABRT  = 6;

    localparam logic [NSRC-1:0] LEVEL_SRC = NSRC'((1 << SRC_RX_FULL) | (1 << SRC_TX_EMPTY));
    localparam logic [NSRC-1:0] HELD_SRC  = ~LEVEL_SRC;

    // register addresses
    localparam int A_MASKED   = 0;
    localparam int A_RAW      = 1;
    localparam int A_MASK     = 2;
    localparam int A_REASON   = 3;
    localparam int A_GCLR     = 4;
    localparam int A_CLR_BASE = 16;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MASKED,
        RS_RAW,
        RS_MASK,
        RS_REASON,
        RS_GCLR,
        RS_ONE
    } rsel_t;

    typedef struct packed {
        rsel_t           sel;
        logic            gclr;
        logic            wr_mask;
        logic [NSRC-1:0] one_hit;
    } acc_t;

    function automatic acc_t decode_access(input int unsigned a, input logic rd, input logic wr);
        acc_t r;
        r.sel     = RS_NONE;
        r.gclr    = 1'b0;
        r.wr_mask = wr && (a == A_MASK);
        r.one_hit = '0;
        for (int b = 0; b < NSRC; b++) begin
            if (a == A_CLR_BASE + b) r.one_hit[b] = rd;
        end
        if (rd) begin
            case (a)
                A_MASKED: r.sel = RS_MASKED;
                A_RAW:    r.sel = RS_RAW;
                A_MASK:   r.sel = RS_MASK;
                A_REASON: r.sel = RS_REASON;
                A_GCLR:   begin r.sel = RS_GCLR; r.gclr = 1'b1; end
                default:  r.sel = (|r.one_hit) ? RS_ONE : RS_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_aggr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] lvl_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] raw_o
);

    logic unused_bits;
    assign unused_bits = ^(lvl_i & HELD_SRC) ^ ^(set_i & LEVEL_SRC) ^ ^(clr_i & LEVEL_SRC);

    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        if (LEVEL_SRC[b]) begin : g_level
            assign raw_o[b] = lvl_i[b];
        end else begin : g_held
            logic q;
            always_ff @(posedge clk) begin
                if (rst)           q <= 1'b0;
                else if (set_i[b]) q <= 1'b1;
                else if (clr_i[b]) q <= 1'b0;
            end
            assign raw_o[b] = q;
        end
    end

endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture
    import irq_aggr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic [ABRT_W-1:0] rsn_i,
    input  logic              clr_i,
    output logic [ABRT_W-1:0] rsn_o
);

    always_ff @(posedge clk) begin
        if (rst)        rsn_o <= '0;
        else if (set_i) rsn_o <= (clr_i ? '0 : rsn_o) | rsn_i;
        else if (clr_i) rsn_o <= '0;
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_aggr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [ABRT_W-1:0] rsn_i,
    output logic [NSRC-1:0]   mask_o,
    output logic [NSRC-1:0]   clr_o,
    output logic              rsn_clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    acc_t              acc;
    logic [DATA_W-1:0] rd_next;
    logic              unused_wdata;

    assign acc          = decode_access(int'(addr_i), rd_en_i, wr_en_i);
    assign unused_wdata = ^wdata_i;

    assign clr_o     = (acc.one_hit | {NSRC{acc.gclr}}) & HELD_SRC;
    assign rsn_clr_o = acc.gclr | acc.one_hit[SRC_TX_ABRT];

    always_comb begin
        case (acc.sel)
            RS_MASKED: rd_next = DATA_W'(raw_i & mask_o);
            RS_RAW:    rd_next = DATA_W'(raw_i);
            RS_MASK:   rd_next = DATA_W'(mask_o);
            RS_REASON: rd_next = DATA_W'(rsn_i);
            RS_GCLR:   rd_next = DATA_W'(|(raw_i & HELD_SRC));
            RS_ONE:    rd_next = DATA_W'(|(acc.one_hit & raw_i & HELD_SRC));
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o  <= '0;
            rdata_o <= '0;
        end else begin
            if (acc.wr_mask) mask_o <= wdata_i[NSRC-1:0];
            if (rd_en_i)     rdata_o <= rd_next;
        end
    end

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       evt_i,
    input  logic              rx_full_lvl_i,
    input  logic              tx_empty_lvl_i,
    input  logic [12:0]       abrt_rsn_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [NSRC-1:0]   lvl_vec;
    logic [NSRC-1:0]   raw_stat;
    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   clr_vec;
    logic              rsn_clr;
    logic [ABRT_W-1:0] abort_reason;

    always_comb begin
        lvl_vec               = '0;
        lvl_vec[SRC_RX_FULL]  = rx_full_lvl_i;
        lvl_vec[SRC_TX_EMPTY] = tx_empty_lvl_i;
    end

    irq_status_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i),
        .lvl_i (lvl_vec),
        .clr_i (clr_vec),
        .raw_o (raw_stat)
    );

    irq_abort_capture u_abrt (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i[SRC_TX_ABRT]),
        .rsn_i (abrt_rsn_i),
        .clr_i (rsn_clr),
        .rsn_o (abort_reason)
    );

    irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .raw_i     (raw_stat),
        .rsn_i     (abort_reason),
        .mask_o    (mask_q),
        .clr_o     (clr_vec),
        .rsn_clr_o (rsn_clr),
        .rdata_o   (rdata_o)
    );

    assign irq_o = |(raw_stat & mask_q);

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   evt_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [NSRC-1:0]   raw,
    input logic [NSRC-1:0]   mask,
    input logic [ABRT_W-1:0] reason,
    input logic              irq_o
);

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (|(evt_i & HELD_SRC)) |=> ((raw & $past(evt_i & HELD_SRC)) == $past(evt_i & HELD_SRC)));

    for (genvar b = 0; b < NSRC; b++) begin : g_clr
        if (HELD_SRC[b]) begin : g_held
            assert_clear_one_R4: assert property (@(posedge clk) disable iff (rst)
                (rd_en_i && addr_i == ADDR_W'(A_CLR_BASE + b) && !evt_i[b]) |=> !raw[b]);
            assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
                (rd_en_i && addr_i == ADDR_W'(A_CLR_BASE + b) && evt_i[b]) |=> raw[b]);
        end
    end

    assert_gclr_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == ADDR_W'(A_GCLR) && !(|(evt_i & HELD_SRC)))
        |=> ((raw & HELD_SRC) == '0 && reason == '0));

    assert_reason_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!evt_i[SRC_TX_ABRT] && !(rd_en_i && (addr_i == ADDR_W'(A_GCLR) ||
                                             addr_i == ADDR_W'(A_CLR_BASE + SRC_TX_ABRT))))
        |=> $stable(reason));

    assert_quiet_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

    assert_mask_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask == '0));

endmodule

bind irq_aggr_top irq_aggr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .raw     (raw_stat),
    .mask    (mask_q),
    .reason  (abort_reason),
    .irq_o   (irq_o)
);

// File: tb/irq_aggr_top_tb_top.sv
`timescale 1ns/1ps
module irq_aggr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] evt = '0;
    logic        rxl = 1'b0;
    logic        txl = 1'b0;
    logic [12:0] rsn = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_aggr_top dut_i (
        .clk(clk), .rst(rst), .evt_i(evt), .rx_full_lvl_i(rxl), .tx_empty_lvl_i(txl),
        .abrt_rsn_i(rsn), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference model
    logic [11:0] m_lat, m_mask;
    logic [12:0] m_rsn;
    logic [15:0] m_rd;

    always @(posedge clk) begin
        logic [11:0] full, clrv;
        logic        gc, rc;
        int          a;
        if (rst) begin
            m_lat = '0; m_mask = '0; m_rsn = '0; m_rd = '0;
        end else begin
            a    = int'(addr);
            full = m_lat | {7'b0, txl, 1'b0, rxl, 2'b0};
            clrv = '0;
            gc   = rd_en && a == 4;
            rc   = gc || (rd_en && a == 22);
            if (rd_en) begin
                if (a == 0)      m_rd = {4'b0, full & m_mask};
                else if (a == 1) m_rd = {4'b0, full};
                else if (a == 2) m_rd = {4'b0, m_mask};
                else if (a == 3) m_rd = {3'b0, m_rsn};
                else if (a == 4) m_rd = {15'b0, |m_lat};
                else if (a >= 16 && a < 28 && a != 18 && a != 20) begin
                    m_rd = {15'b0, m_lat[a-16]};
                    clrv[a-16] = 1'b1;
                end else m_rd = '0;
            end
            if (gc) clrv = 12'hFEB;
            m_lat = (m_lat & ~clrv) | (evt & 12'hFEB);
            if (evt[6])  m_rsn = (rc ? 13'h0 : m_rsn) | rsn;
            else if (rc) m_rsn = '0;
            if (wr_en && a == 2) m_mask = wdata[11:0];
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            logic [11:0] full;
            full = m_lat | {7'b0, txl, 1'b0, rxl, 2'b0};
            check("R8 irq", {15'b0, irq}, {15'b0, |(full & m_mask)});
            check("R10 rdata", rdata, m_rd);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        rd_en = 1'b1; addr = 5'(a);
        cyc();
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] e, input logic [12:0] r);
        evt = e; rsn = r;
        cyc();
        evt = '0; rsn = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) cyc();
        rst = 1'b0;
        check("R9 reset irq", {15'b0, irq}, 16'h0);
        check("R9 reset rdata", rdata, 16'h0);
        rd(2, v);        check("R9 mask after reset", v, 16'h0);

        pulse(12'h201, 13'h0);
        rd(1, v);        check("R1 raw held bits", v, 16'h0201);
        check("R8 masked off", {15'b0, irq}, 16'h0);
        wr(2, 16'h0FFF);
        check("R8 irq on", {15'b0, irq}, 16'h1);
        rd(0, v);        check("R3 masked all", v, 16'h0201);
        wr(2, 16'h0200);
        rd(0, v);        check("R3 masked part", v, 16'h0200);
        wr(2, 16'h0FFF);

        rxl = 1'b1;
        rd(1, v);        check("R2 level shows", v, 16'h0205);
        rd(18, v);       check("R2 level clear returns 0", v, 16'h0);
        rd(1, v);        check("R2 level unaffected", v, 16'h0205);
        pulse(12'h004, 13'h0);
        rxl = 1'b0;
        rd(1, v);        check("R2 level follows input", v, 16'h0201);

        rd(16, v);       check("R4 clear returns bit", v, 16'h1);
        rd(1, v);        check("R4 only that bit", v, 16'h0200);
        rd(16, v);       check("R4 second clear", v, 16'h0);

        pulse(12'h040, 13'h1008);
        pulse(12'h040, 13'h0001);
        rd(3, v);        check("R6 reason accumulates", v, 16'h1009);
        rd(1, v);        check("R6 abort bit", v, 16'h0240);
        rd(3, v);        check("R6 reason holds", v, 16'h1009);
        rd(22, v);       check("R6 abort clear", v, 16'h1);
        rd(3, v);        check("R6 reason cleared", v, 16'h0);

        evt = 12'h200; rd(25, v); evt = '0;
        check("R7 clear read value", v, 16'h1);
        rd(1, v);        check("R7 set wins", v, 16'h0200);
        pulse(12'h040, 13'h0800);
        evt = 12'h040; rsn = 13'h0004; rd(22, v); evt = '0; rsn = '0;
        rd(3, v);        check("R7 reason set wins", v, 16'h0004);
        rd(1, v);        check("R7 abort bit set wins", v, 16'h0240);

        pulse(12'h800, 13'h0);
        txl = 1'b1;
        rd(4, v);        check("R5 global clear any", v, 16'h1);
        rd(1, v);        check("R5 held cleared", v, 16'h0010);
        rd(3, v);        check("R5 reason cleared", v, 16'h0);
        rd(4, v);        check("R5 global clear none", v, 16'h0);
        txl = 1'b0;

        pulse(12'h001, 13'h0);
        rd(1, v);        check("R10 read value", v, 16'h0001);
        cyc();
        pulse(12'h002, 13'h0);
        cyc();
        check("R10 holds", rdata, 16'h0001);

        for (int i = 0; i < 3000; i++) begin
            evt   = ($urandom % 4 == 0) ? 12'($urandom) : 12'h0;
            rsn   = 13'($urandom);
            rxl   = 1'($urandom);
            txl   = 1'($urandom);
            rd_en = ($urandom % 3 == 0);
            wr_en = ($urandom % 10 == 0);
            addr  = ($urandom % 2 == 0) ? 5'($urandom % 5) : 5'($urandom);
            wdata = 16'($urandom);
            cyc();
        end
        evt = '0; rd_en = 1'b0; wr_en = 1'b0;
        cyc();
        finish_run();
    end

endmodule